// File: doc/BRIEF.md
# TDM Loopback Timeslot Switch

This block sits on one serial TDM port that carries 32 eight-bit channels per frame. A frame pulse marks the first bit period of timeslot 0, and each clock cycle is one bit period. The block offers two test loopbacks of the incoming stream back onto the outgoing line. The first is a plain bit-level echo with a fixed two-period delay. The second is a timeslot switch. Each outgoing timeslot looks up its own programmable entry. That entry either names the input channel, taken from the previous frame, to send in the slot, or it leaves the slot undriven.

Incoming channels are assembled into bytes and stored in one half of a two-bank frame store while the other half is read, so the timeslot path has a fixed delay of one frame. Entries and mode bits are loaded through a single-cycle address/data write port. Entry writes are held in a shadow table, and that table is copied into the working table on the frame pulse. A single-stream loopback, a partial loopback with the other slots tristated, and any reordering of channels inside the port all use this one mechanism.

Top module: `tdm_lpbk_switch`

## Requirements
- R1: While reset is asserted, and after reset until a mode is enabled, `sdo_oe` and `sdo` are both 0.
- R2: With the bypass enable (control bit 0 at address 32) set, `sdo_oe` is 1 and `sdo` in each bit period equals `sdi` two bit periods earlier.
- R3: When both enables are set, the bypass behaviour of R2 applies and the timeslot entries have no effect.
- R4: With both enables clear (control bits 0 and 1 at address 32), `sdo_oe` and `sdo` are 0.
- R5: With only the timeslot enable (control bit 1) set, bit k (k = 0 is the MSB) of output timeslot n is driven in bit period 8n+k after the frame pulse, and the frame pulse cycle is period 0. That bit is the same bit of input channel S as it arrived in the previous frame, where S is the entry's source field (entry bits 5:1), and `sdo_oe` is 1.
- R6: In timeslot mode, when an entry's valid bit (entry bit 15) is clear, `sdo_oe` and `sdo` are 0 for all 8 bit periods of that timeslot.
- R7: Entry bit 0, entry bits 9:6, the three flag bits 12:10 and bits 14:13 have no effect on the output, whatever value is written to them.
- R8: An entry written at addresses 0 to 31 during a frame does not change that frame's output. It takes effect from the next frame pulse. A write made in the pulse cycle itself waits for the pulse after that.
- R9: A write to an address from 33 to 63 changes neither the mode nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fp | input | 1 | Frame pulse, high in bit period 0 of timeslot 0 |
| sdi | input | 1 | Serial data in, MSB first |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | 0 to 31: timeslot entry, 32: mode control |
| cfg_wdata | input | 16 | Write data |
| sdo | output | 1 | Serial data out, 0 when not driven |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The bench aims at the frame edge. It checks that a read taken in the pulse cycle comes from the bank just completed and not from the bank now being filled. A design that swapped banks one cycle late would send the first bit of timeslot 0 from a frame too old or too new. An entry rewritten mid-frame, for a slot later in that same frame, must not change that slot until the next pulse. A design that skipped the shadow table would switch channels mid-frame. Entries written with junk in every ignored bit, and writes to unmapped addresses, catch a decoder that reads the wrong field or aliases the address space. Running both enables together catches a wrong priority order.

// File: rtl/tdm_lpbk_pkg.sv
// Package: shared field positions and the output mode type for the
// TDM loopback timeslot switch. Assumes a 16-bit register data word.
package tdm_lpbk_pkg;

    localparam int ENT_VALID_BIT   = 15;
    localparam int ENT_SRC_LSB     = 1;
    localparam int CTRL_BYPASS_BIT = 0;
    localparam int CTRL_SLOT_BIT   = 1;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_BYPASS = 2'd1,
        OUT_SLOT   = 2'd2
    } out_mode_e;

    // Bypass outranks the timeslot path; no enable means no drive.
    function automatic out_mode_e pick_mode(input logic byp, input logic slot);
        if (byp)       return OUT_BYPASS;
        else if (slot) return OUT_SLOT;
        else           return OUT_OFF;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
// Frame timer: tracks the bit period inside the frame and the frame-store
// bank selection. Assumes the frame length is 2**POS_W bit periods and that
// fp, when present, marks period 0. Without fp the count wraps on its own.
module tdm_frame_timer #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp,
    output logic [POS_W-1:0] pos,
    output logic             wr_bank,
    output logic             bank_q
);

    logic [POS_W-1:0] cnt_q;

    // Current bit period: forced to zero by the frame pulse.
    always_comb pos = fp ? '0 : cnt_q + 1'b1;

    // Bank being filled in this cycle; flips within the pulse cycle.
    assign wr_bank = bank_q ^ fp;

    // Hold the period count and toggle the bank on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            bank_q <= 1'b0;
        end else begin
            cnt_q <= pos;
            if (fp) bank_q <= ~bank_q;
        end
    end

endmodule

// File: rtl/tdm_chan_store.sv
// Channel store: shifts serial input into bytes and writes each finished
// byte into the bank being filled. It reads one bit of a chosen channel
// from the other bank. Assumes NUM_CH and CH_W are powers of two, CH_W >= 4.
module tdm_chan_store #(
    parameter int NUM_CH = 32,
    parameter int CH_W   = 8,
    localparam int SRC_W = $clog2(NUM_CH),
    localparam int BIT_W = $clog2(CH_W),
    localparam int POS_W = SRC_W + BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic [POS_W-1:0] pos,
    input  logic             wr_bank,
    input  logic [SRC_W-1:0] rd_src,
    output logic             rd_bit
);

    logic [CH_W-2:0]  sh_q;
    logic [CH_W-1:0]  mem_q [2][NUM_CH];
    logic [SRC_W-1:0] wr_ch;
    logic [BIT_W-1:0] bit_idx;
    logic             byte_done;

    assign wr_ch     = pos[POS_W-1:BIT_W];
    assign bit_idx   = pos[BIT_W-1:0];
    assign byte_done = (bit_idx == BIT_W'(CH_W - 1));

    // Collect the leading bits of the channel now arriving.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[CH_W-3:0], sdi};
    end

    // Commit a completed byte to its channel slot in the fill bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < NUM_CH; c++)
                    mem_q[b][c] <= '0;
        end else if (byte_done) begin
            mem_q[wr_bank][wr_ch] <= {sh_q, sdi};
        end
    end

    // Read the bit for this period from the completed bank, MSB first.
    always_comb rd_bit = mem_q[~wr_bank][rd_src][BIT_W'(CH_W - 1) - bit_idx];

endmodule

// File: rtl/tdm_slot_map.sv
// Slot map: decodes register writes into the mode enables and a shadow
// entry table. It copies the shadow into the working table on each frame
// pulse and presents the entry for the current timeslot. Assumes NUM_CH is
// a power of two and the address space is wider than the entry range.
module tdm_slot_map
    import tdm_lpbk_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int CFG_AW = 6,
    parameter int CFG_DW = 16,
    localparam int SRC_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp,
    input  logic [SRC_W-1:0]  slot,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              ent_vld,
    output logic [SRC_W-1:0]  ent_src,
    output logic              byp_en,
    output logic              tsl_en
);

    typedef struct packed {
        logic             vld;
        logic [SRC_W-1:0] src;
    } ent_t;

    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(NUM_CH);

    ent_t shadow_q [NUM_CH];
    ent_t active_q [NUM_CH];
    ent_t wr_ent;
    ent_t cur_ent;
    logic ent_hit;
    logic ctrl_hit;
    logic unused_wdata;

    assign ent_hit      = cfg_we && (cfg_addr[CFG_AW-1:SRC_W] == '0);
    assign ctrl_hit     = cfg_we && (cfg_addr == CTRL_ADDR);
    assign unused_wdata = ^cfg_wdata[ENT_VALID_BIT-1:ENT_SRC_LSB+SRC_W];

    // Keep only the fields that steer the output.
    always_comb begin
        wr_ent.vld = cfg_wdata[ENT_VALID_BIT];
        wr_ent.src = cfg_wdata[ENT_SRC_LSB +: SRC_W];
    end

    // Shadow table: takes register writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) shadow_q[i] <= '0;
        end else if (ent_hit) begin
            shadow_q[cfg_addr[SRC_W-1:0]] <= wr_ent;
        end
    end

    // Working table: reloaded from the shadow once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) active_q[i] <= '0;
        end else if (fp) begin
            for (int i = 0; i < NUM_CH; i++) active_q[i] <= shadow_q[i];
        end
    end

    // Mode enables: direct register bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_en <= 1'b0;
            tsl_en <= 1'b0;
        end else if (ctrl_hit) begin
            byp_en <= cfg_wdata[CTRL_BYPASS_BIT];
            tsl_en <= cfg_wdata[CTRL_SLOT_BIT];
        end
    end

    // Entry for this period; in the pulse cycle the new table is not loaded yet.
    always_comb begin
        cur_ent = fp ? shadow_q[slot] : active_q[slot];
        ent_vld = cur_ent.vld;
        ent_src = cur_ent.src;
    end

endmodule

// File: rtl/tdm_bit_bypass.sv
// Bit bypass: a fixed delay line from serial input to serial output.
// Assumes DLY >= 1; the one-stage case uses a plain flop.
module tdm_bit_bypass #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (DLY == 1) begin : g_single
            logic d_q;
            // One-period echo.
            always_ff @(posedge clk) begin
                if (!rst_n) d_q <= 1'b0;
                else        d_q <= din;
            end
            assign dout = d_q;
        end else begin : g_chain
            logic [DLY-1:0] pipe_q;
            // Multi-period echo through a shift chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[DLY-2:0], din};
            end
            assign dout = pipe_q[DLY-1];
        end
    endgenerate

endmodule

// File: rtl/tdm_lpbk_switch.sv
// Top: per-port TDM loopback with a bit-level bypass and a timeslot switch
// that has one frame of delay. Assumes one clock cycle per bit period and
// a frame of NUM_CH*CH_W periods marked by fp.
module tdm_lpbk_switch
    import tdm_lpbk_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int CH_W    = 8,
    parameter int CFG_AW  = 6,
    parameter int CFG_DW  = 16,
    parameter int BYP_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp,
    input  logic              sdi,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int SRC_W = $clog2(NUM_CH);
    localparam int BIT_W = $clog2(CH_W);
    localparam int POS_W = SRC_W + BIT_W;

    logic [POS_W-1:0] pos;
    logic             wr_bank;
    logic             bank_q;
    logic             ent_vld;
    logic [SRC_W-1:0] ent_src;
    logic             byp_en;
    logic             tsl_en;
    logic             slot_bit;
    logic             byp_bit;
    out_mode_e        mode;

    tdm_frame_timer #(.POS_W(POS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fp      (fp),
        .pos     (pos),
        .wr_bank (wr_bank),
        .bank_q  (bank_q)
    );

    tdm_chan_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdi     (sdi),
        .pos     (pos),
        .wr_bank (wr_bank),
        .rd_src  (ent_src),
        .rd_bit  (slot_bit)
    );

    tdm_slot_map #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp        (fp),
        .slot      (pos[POS_W-1:BIT_W]),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ent_vld   (ent_vld),
        .ent_src   (ent_src),
        .byp_en    (byp_en),
        .tsl_en    (tsl_en)
    );

    tdm_bit_bypass #(.DLY(BYP_DLY)) u_bypass (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sdi),
        .dout  (byp_bit)
    );

    assign mode = pick_mode(byp_en, tsl_en);

    // Output select: bypass, gated timeslot data, or idle.
    always_comb begin
        case (mode)
            OUT_BYPASS: begin
                sdo_oe = 1'b1;
                sdo    = byp_bit;
            end
            OUT_SLOT: begin
                sdo_oe = ent_vld;
                sdo    = ent_vld & slot_bit;
            end
            default: begin
                sdo_oe = 1'b0;
                sdo    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tdm_lpbk_switch_chk.sv
// Checker: temporal properties of the loopback switch, bound to the top.
module tdm_lpbk_switch_chk (
    input logic clk,
    input logic rst_n,
    input logic fp,
    input logic sdi,
    input logic sdo,
    input logic sdo_oe,
    input logic byp_en,
    input logic tsl_en,
    input logic bank
);

    p_bypass_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_en && $past(byp_en, 2)) |-> (sdo == $past(sdi, 2)));

    p_bypass_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byp_en |-> sdo_oe);

    p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_en && !tsl_en) |-> !sdo_oe);

    p_quiet_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    p_bank_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> (bank != $past(bank)));

    p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fp |=> $stable(bank));

endmodule

bind tdm_lpbk_switch tdm_lpbk_switch_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .fp     (fp),
    .sdi    (sdi),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .byp_en (byp_en),
    .tsl_en (tsl_en),
    .bank   (bank_q)
);

// File: tb/tdm_lpbk_switch_tb.sv
module tdm_lpbk_switch_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fp;
    logic        sdi;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        sdo;
    logic        sdo_oe;

    always #2 clk = ~clk;

    tdm_lpbk_switch u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp        (fp),
        .sdi       (sdi),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    typedef struct {
        logic  oe;
        logic  dat;
        string tag;
    } exp_t;

    typedef struct {
        logic [5:0]  a;
        logic [15:0] d;
    } wr_t;

    exp_t exp_q[$];
    wr_t  wq[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Reference model state, built from the requirements.
    bit       m_svld[32];
    bit [4:0] m_ssrc[32];
    bit       m_avld[32];
    bit [4:0] m_asrc[32];
    bit       m_byp, m_tsl;
    bit [7:0] m_prev[32];
    bit [7:0] m_cur[32];
    bit       h1, h2;
    int       pos = 0;
    int       wr_from = 0;
    string    phase = "";

    task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: {oe,sdo} actual=%b expected=%b", tag, act, expv);
        end
    endtask

    // Driver: one bit period; drives inputs and pushes the expected output.
    task automatic step(input bit f, input bit d);
        exp_t e;
        wr_t  w;
        bit   wr = 1'b0;
        int   ts, k;
        @(negedge clk);
        fp = f; sdi = d; cfg_we = 1'b0;
        pos = f ? 0 : (pos + 1) % 256;
        if (wq.size() > 0 && pos >= wr_from) begin
            w = wq.pop_front();
            wr = 1'b1;
            cfg_we = 1'b1; cfg_addr = w.a; cfg_wdata = w.d;
        end
        if (f) begin
            for (int i = 0; i < 32; i++) begin
                m_avld[i] = m_svld[i];
                m_asrc[i] = m_ssrc[i];
                m_prev[i] = m_cur[i];
            end
        end
        ts = pos / 8;
        k  = pos % 8;
        if (m_byp) begin
            e.oe = 1'b1; e.dat = h2;
            e.tag = m_tsl ? "R3" : "R2";
        end else if (m_tsl) begin
            if (m_avld[ts]) begin
                e.oe = 1'b1; e.dat = m_prev[m_asrc[ts]][7-k]; e.tag = "R5";
            end else begin
                e.oe = 1'b0; e.dat = 1'b0; e.tag = "R6";
            end
        end else begin
            e.oe = 1'b0; e.dat = 1'b0; e.tag = "R4";
        end
        e.tag = {e.tag, " ", phase};
        exp_q.push_back(e);
        h2 = h1; h1 = d;
        m_cur[ts][7-k] = d;
        if (wr) begin
            if (w.a < 32) begin
                m_svld[w.a] = w.d[15];
                m_ssrc[w.a] = w.d[5:1];
            end else if (w.a == 32) begin
                m_byp = w.d[0];
                m_tsl = w.d[1];
            end
        end
    endtask

    function automatic bit [7:0] pat(input int seed, input int ch);
        return 8'((seed * 37 + ch * 11 + 5) & 255);
    endfunction

    task automatic send_frame(input int seed);
        bit [7:0] b;
        for (int p = 0; p < 256; p++) begin
            b = pat(seed, p / 8);
            step(p == 0, b[7 - (p % 8)]);
        end
    endtask

    task automatic qwr(input logic [5:0] a, input logic [15:0] d);
        wr_t w;
        w.a = a; w.d = d;
        wq.push_back(w);
    endtask

    // Monitor: pops the expected item and compares it away from the edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk((sdo_oe === e.oe) && (sdo === e.dat), e.tag, {sdo_oe, sdo}, {e.oe, e.dat});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fp = 1'b0; sdi = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int i = 0; i < 32; i++) begin
            m_svld[i] = 0; m_ssrc[i] = 0; m_avld[i] = 0; m_asrc[i] = 0;
            m_prev[i] = 0; m_cur[i] = 0;
        end
        m_byp = 0; m_tsl = 0; h1 = 0; h2 = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(!sdo_oe && !sdo, "R1 reset", {sdo_oe, sdo}, 2'b00);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!sdo_oe && !sdo, "R1 after reset", {sdo_oe, sdo}, 2'b00);

        phase = "idle";
        send_frame(1);

        phase = "bypass";
        qwr(6'd32, 16'h0001);
        send_frame(2);
        send_frame(3);

        phase = "entries load";
        for (int n = 0; n < 32; n++) qwr(6'(n), 16'h8001 | 16'(n << 1));
        qwr(6'd32, 16'h0003);
        send_frame(4);
        send_frame(5);

        phase = "whole stream";
        qwr(6'd32, 16'h0002);
        send_frame(6);
        send_frame(7);
        send_frame(8);

        phase = "R7 reorder with junk bits";
        for (int n = 0; n < 32; n++)
            qwr(6'(n), ((n % 3 != 0) ? 16'h8000 : 16'h0000) | 16'h7FC0 | 16'((31 - n) << 1));
        send_frame(9);
        send_frame(10);
        send_frame(11);

        phase = "R8 mid-frame entry write";
        wr_from = 100;
        qwr(6'd20, 16'h8000);
        send_frame(12);
        wr_from = 0;
        send_frame(13);

        phase = "R9 unmapped writes";
        qwr(6'd40, 16'h0000);
        qwr(6'd63, 16'hFFFF);
        qwr(6'd33, 16'h0001);
        send_frame(14);
        send_frame(15);

        phase = "off";
        qwr(6'd32, 16'h0000);
        send_frame(16);

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule